// File: doc/BRIEF.md
# Power-Up Strap Latch and Frequency Mode Selector

This block sits between a set of dual-purpose pins and the clock synthesis control of a clock generator. While the active-low power-good strobe is held low, the pins behave as inputs. The block samples the frequency-select straps, the two early-clock offset straps and the bus-clock source strap on every clock. The first rising edge of the strobe commits the last sampled set into a latch. The latch then holds its value until the next reset. Only after the capture does the block raise the output enables that turn the pins into clock outputs.

The committed straps feed the programmed frequency-select code. Software can replace either of the two upper select bits on its own through a per-bit write strobe. A live power-save input forces the upper three select bits to the power-save pattern and leaves the two lower gear bits alone. The block decodes the effective code into a spread kind, a spread step and an overclock step. The programmed code, the offset code and the source select can all be read back.

Top module: `fsel_strap_select`

## Requirements
- R1: While reset is asserted, `fs_code_o`, `fs_rb_o` and `pin_oe_o` are all zero and `strap_done_o` is 0.
- R2: The straps are sampled on each clock edge at which `pwrgd_n_i` is low. At the first edge at which `pwrgd_n_i` is high after a low sample, the values sampled at the previous edge are committed. `strap_done_o` rises in the cycle after that edge, and `fs_rb_o` shows the committed select straps in the same cycle.
- R3: After the commit, changes on the strap pins and further low pulses of `pwrgd_n_i` leave `fs_rb_o`, `epci_code_o` and `asrc_main_o` unchanged until the next reset.
- R4: `pin_oe_o` stays all zero up to and including the cycle in which `strap_done_o` first reads 1. It becomes all ones one cycle later and stays all ones. Bit order is {source strap, offset straps[1:0], select straps[4:0]}.
- R5: `epci_code_o` equals the committed offset straps, coded 0 = 0 ns, 1 = 0.5 ns, 2 = 1.0 ns, 3 = 1.5 ns of early lead.
- R6: `asrc_main_o` equals the committed source strap: 1 selects the main PLL and 0 selects the fixed asynchronous PLL.
- R7: An edge with `ovr_wr_en_i[i]` high sets select bit 3+i of `fs_rb_o` and `fs_code_o` to `ovr_wr_data_i[i]` from the next cycle on. A bit without its enable keeps its previous source, and bits 2..0 always come from the straps.
- R8: One cycle after `psave_n_i` is sampled low, `fs_code_o[4:2]` is 3'b100 and `fs_code_o[1:0]` equals `fs_rb_o[1:0]`. One cycle after it is sampled high, `fs_code_o` equals `fs_rb_o` again. `fs_rb_o` is never affected by `psave_n_i`.
- R9: The mode outputs follow `fs_code_o[4:2]` (h) in the same cycle. For h = 0..3, `spread_kind_o` is 1 (center) when h is even and 2 (down) when h is odd, `spread_step_o` = h (0.3%, 0.5%, 0.55%, 0.75%), and `ovclk_step_o` = 0. For h = 4, the kind, step and overclock are 0 (spread off) and `psave_mode_o` = 1. For h = 5..7, the kind is 1, the step is 0 and `ovclk_step_o` = h-4 (3%, 5%, 10%). `psave_mode_o` is 0 except when h = 4.
- R10: Reset clears the override flags, so after a reset and a new capture, `fs_rb_o` equals the straps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd_n_i | input | 1 | Active-low strap-valid strobe |
| fs_pin_i | input | 5 | Frequency-select strap pin levels |
| epci_pin_i | input | 2 | Early-clock offset strap pin levels |
| asel_pin_i | input | 1 | Bus-clock source strap pin level |
| psave_n_i | input | 1 | Active-low live power-save request |
| ovr_wr_en_i | input | 2 | Per-bit write strobes for select bits 4:3 |
| ovr_wr_data_i | input | 2 | Write data for select bits 4:3 |
| fs_code_o | output | 5 | Effective frequency-select code |
| spread_kind_o | output | 2 | 0 off, 1 center, 2 down |
| spread_step_o | output | 2 | Spread amount step |
| ovclk_step_o | output | 2 | Overclock step, 0 none |
| psave_mode_o | output | 1 | Effective code is the power-save mode |
| pin_oe_o | output | 8 | Output enables of the shared pins |
| fs_rb_o | output | 5 | Programmed code readback (straps plus overrides) |
| epci_code_o | output | 2 | Committed early-clock offset code |
| asrc_main_o | output | 1 | Committed bus-clock source select |
| strap_done_o | output | 1 | Strap capture completed |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. The commit, the readback and `strap_done_o` follow the strobe's rising sample by one edge. A power-save change or an override write shows on `fs_code_o` after one edge. The output enables come one edge after `strap_done_o`. The mode outputs are combinational on `fs_code_o`, so they are due in the same cycle as the code. The bench drives inputs one nanosecond after a rising edge and checks one nanosecond after the next rising edge, so each check looks at exactly the cycle in which its result is due. A sweep of all 256 strap combinations repeats these checks, and each combination also gets a power-save toggle and an override write.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;
  typedef enum logic [1:0] {
    SPR_OFF    = 2'd0,
    SPR_CENTER = 2'd1,
    SPR_DOWN   = 2'd2
  } spread_e;

  localparam logic [2:0] PSAVE_HI_DEF = 3'b100;
endpackage

// File: rtl/fsel_strap_latch.sv
`timescale 1ns/1ps
module fsel_strap_latch #(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_n_i,
  input  logic [PIN_W-1:0] pins_i,
  output logic [PIN_W-1:0] latched_o,
  output logic             done_o,
  output logic [PIN_W-1:0] oe_o
);
  logic             strobe_q, done_q, oe_q;
  logic [PIN_W-1:0] shadow_q, lat_q;
  logic             strobe_d, done_d, oe_d, capture;
  logic [PIN_W-1:0] shadow_d, lat_d;

  // next state
  always_comb begin
    capture  = strobe_n_i & ~strobe_q & ~done_q;
    strobe_d = strobe_n_i;
    shadow_d = (~strobe_n_i & ~done_q) ? pins_i : shadow_q;
    lat_d    = capture ? shadow_q : lat_q;
    done_d   = done_q | capture;
    oe_d     = done_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      done_q   <= 1'b0;
      oe_q     <= 1'b0;
      shadow_q <= '0;
      lat_q    <= '0;
    end else begin
      strobe_q <= strobe_d;
      done_q   <= done_d;
      oe_q     <= oe_d;
      shadow_q <= shadow_d;
      lat_q    <= lat_d;
    end
  end

  assign latched_o = lat_q;
  assign done_o    = done_q;
  assign oe_o      = {PIN_W{oe_q}};

  assert_oe_after_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |=> (oe_o == {PIN_W{1'b1}}));
  assert_no_oe_before_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> (oe_o == '0));
  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> $stable(lat_q));
endmodule

// File: rtl/fsel_override.sv
`timescale 1ns/1ps
module fsel_override #(
  parameter int FS_W  = 5,
  parameter int OVR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OVR_W-1:0] wr_en_i,
  input  logic [OVR_W-1:0] wr_data_i,
  input  logic [FS_W-1:0]  lat_i,
  output logic [FS_W-1:0]  prog_o
);
  localparam int BASE = FS_W - OVR_W;

  assign prog_o[BASE-1:0] = lat_i[BASE-1:0];

  for (genvar i = 0; i < OVR_W; i++) begin : g_ovr
    logic vld_q, val_q, vld_d, val_d;

    always_comb begin
      vld_d = vld_q | wr_en_i[i];
      val_d = wr_en_i[i] ? wr_data_i[i] : val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        val_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
        val_q <= val_d;
      end
    end

    assign prog_o[BASE+i] = vld_q ? val_q : lat_i[BASE+i];

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i[i] |=> (prog_o[BASE+i] == $past(wr_data_i[i])));
  end
endmodule

// File: rtl/fsel_psave_merge.sv
`timescale 1ns/1ps
module fsel_psave_merge #(
  parameter int              FS_W     = 5,
  parameter int              HI_W     = 3,
  parameter logic [HI_W-1:0] PSAVE_HI = 3'b100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psave_n_i,
  input  logic [FS_W-1:0] prog_i,
  output logic [FS_W-1:0] code_o
);
  localparam int LO_W = FS_W - HI_W;

  logic psave_q, psave_d;

  always_comb psave_d = psave_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psave_q <= 1'b1;
    else        psave_q <= psave_d;
  end

  assign code_o = psave_q ? prog_i : {PSAVE_HI, prog_i[LO_W-1:0]};

  assert_psave_forces_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !psave_n_i |=> (code_o[FS_W-1 -: HI_W] == PSAVE_HI) && (code_o[LO_W-1:0] == prog_i[LO_W-1:0]));
  assert_psave_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    psave_n_i |=> (code_o == prog_i));
endmodule

// File: rtl/fsel_mode_decode.sv
`timescale 1ns/1ps
module fsel_mode_decode
  import fsel_pkg::*;
#(
  parameter int              HI_W     = 3,
  parameter logic [HI_W-1:0] PSAVE_HI = 3'b100
) (
  input  logic [HI_W-1:0] hi_i,
  output logic [1:0]      spread_o,
  output logic [1:0]      step_o,
  output logic [1:0]      ovclk_o,
  output logic            psave_o
);
  always_comb begin
    spread_o = SPR_CENTER;
    step_o   = 2'd0;
    ovclk_o  = 2'd0;
    psave_o  = 1'b0;
    if (hi_i == PSAVE_HI) begin
      spread_o = SPR_OFF;
      psave_o  = 1'b1;
    end else if (hi_i > PSAVE_HI) begin
      ovclk_o = 2'(hi_i - PSAVE_HI);
    end else begin
      spread_o = hi_i[0] ? SPR_DOWN : SPR_CENTER;
      step_o   = hi_i[1:0];
    end
  end
endmodule

// File: rtl/fsel_strap_select.sv
`timescale 1ns/1ps
module fsel_strap_select
  import fsel_pkg::*;
#(
  parameter int FS_W  = 5,
  parameter int HI_W  = 3,
  parameter int OVR_W = 2,
  parameter int EP_W  = 2,
  localparam int PIN_W = FS_W + EP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrgd_n_i,
  input  logic [FS_W-1:0]  fs_pin_i,
  input  logic [EP_W-1:0]  epci_pin_i,
  input  logic             asel_pin_i,
  input  logic             psave_n_i,
  input  logic [OVR_W-1:0] ovr_wr_en_i,
  input  logic [OVR_W-1:0] ovr_wr_data_i,
  output logic [FS_W-1:0]  fs_code_o,
  output logic [1:0]       spread_kind_o,
  output logic [1:0]       spread_step_o,
  output logic [1:0]       ovclk_step_o,
  output logic             psave_mode_o,
  output logic [PIN_W-1:0] pin_oe_o,
  output logic [FS_W-1:0]  fs_rb_o,
  output logic [EP_W-1:0]  epci_code_o,
  output logic             asrc_main_o,
  output logic             strap_done_o
);
  localparam int EP_LSB = FS_W;
  localparam int AS_BIT = FS_W + EP_W;

  logic [PIN_W-1:0] pins, lat;
  logic [FS_W-1:0]  prog;

  assign pins = {asel_pin_i, epci_pin_i, fs_pin_i};

  fsel_strap_latch #(.PIN_W(PIN_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .strobe_n_i(pwrgd_n_i), .pins_i(pins),
    .latched_o(lat), .done_o(strap_done_o), .oe_o(pin_oe_o)
  );

  fsel_override #(.FS_W(FS_W), .OVR_W(OVR_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .wr_en_i(ovr_wr_en_i), .wr_data_i(ovr_wr_data_i),
    .lat_i(lat[FS_W-1:0]), .prog_o(prog)
  );

  fsel_psave_merge #(.FS_W(FS_W), .HI_W(HI_W), .PSAVE_HI(HI_W'(PSAVE_HI_DEF))) u_merge (
    .clk(clk), .rst_n(rst_n), .psave_n_i(psave_n_i), .prog_i(prog), .code_o(fs_code_o)
  );

  fsel_mode_decode #(.HI_W(HI_W), .PSAVE_HI(HI_W'(PSAVE_HI_DEF))) u_dec (
    .hi_i(fs_code_o[FS_W-1 -: HI_W]), .spread_o(spread_kind_o), .step_o(spread_step_o),
    .ovclk_o(ovclk_step_o), .psave_o(psave_mode_o)
  );

  assign fs_rb_o     = prog;
  assign epci_code_o = lat[EP_LSB +: EP_W];
  assign asrc_main_o = lat[AS_BIT];

  assert_ovclk_center_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovclk_step_o != 2'd0) |-> (spread_kind_o == SPR_CENTER));
  assert_psave_spread_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    psave_mode_o |-> (spread_kind_o == SPR_OFF) && (ovclk_step_o == 2'd0));
endmodule

// File: tb/fsel_strap_select_tb.sv
`timescale 1ns/1ps
module fsel_strap_select_tb;
  logic       clk = 1'b0;
  logic       rst_n, pwrgd_n, asel, psave_n;
  logic [4:0] fs_pin;
  logic [1:0] epci_pin, wr_en, wr_data;
  logic [4:0] fs_code, fs_rb;
  logic [1:0] kind, step, ovclk, epci_code;
  logic       psave_mode, asrc, done;
  logic [7:0] pin_oe;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fsel_strap_select u_dut (
    .clk(clk), .rst_n(rst_n), .pwrgd_n_i(pwrgd_n), .fs_pin_i(fs_pin),
    .epci_pin_i(epci_pin), .asel_pin_i(asel), .psave_n_i(psave_n),
    .ovr_wr_en_i(wr_en), .ovr_wr_data_i(wr_data), .fs_code_o(fs_code),
    .spread_kind_o(kind), .spread_step_o(step), .ovclk_step_o(ovclk),
    .psave_mode_o(psave_mode), .pin_oe_o(pin_oe), .fs_rb_o(fs_rb),
    .epci_code_o(epci_code), .asrc_main_o(asrc), .strap_done_o(done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9 expected mode from the upper three bits
  task automatic chk_mode(logic [4:0] code);
    int h = int'(code[4:2]);
    int ek, es, eo, ep;
    if (h == 4) begin ek = 0; es = 0; eo = 0; ep = 1; end
    else if (h > 4) begin ek = 1; es = 0; eo = h - 4; ep = 0; end
    else begin ek = (h % 2 == 1) ? 2 : 1; es = h; eo = 0; ep = 0; end
    chk("R9 kind", 32'(kind), 32'(ek));
    chk("R9 step", 32'(step), 32'(es));
    chk("R9 ovclk", 32'(ovclk), 32'(eo));
    chk("R9 psave_mode", 32'(psave_mode), 32'(ep));
  endtask

  task automatic run_one(int p);
    logic [4:0] fs = p[4:0];
    logic [1:0] ep = p[6:5];
    logic       as = p[7];
    logic [1:0] en;
    logic [1:0] dat;
    logic [4:0] exp;
    rst_n = 1'b0; pwrgd_n = 1'b0; psave_n = 1'b1; wr_en = '0; wr_data = '0;
    fs_pin = fs; epci_pin = ep; asel = as;
    tick(); tick();
    chk("R1 fs_code", 32'(fs_code), 0);
    chk("R1 fs_rb", 32'(fs_rb), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 done", 32'(done), 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R4 oe while sampling", 32'(pin_oe), 0);
    chk("R2 done before commit", 32'(done), 0);
    pwrgd_n = 1'b1;
    tick();
    chk("R2 done", 32'(done), 1);
    chk("R2 R10 fs_rb", 32'(fs_rb), 32'(fs));
    chk("R2 fs_code", 32'(fs_code), 32'(fs));
    chk("R5 epci_code", 32'(epci_code), 32'(ep));
    chk("R6 asrc", 32'(asrc), 32'(as));
    chk("R4 oe low at commit", 32'(pin_oe), 0);
    tick();
    chk("R4 oe high", 32'(pin_oe), 32'hFF);
    fs_pin = ~fs; epci_pin = ~ep; asel = ~as; pwrgd_n = 1'b0;
    tick(); tick();
    pwrgd_n = 1'b1;
    tick(); tick();
    chk("R3 fs_rb", 32'(fs_rb), 32'(fs));
    chk("R3 epci", 32'(epci_code), 32'(ep));
    chk("R3 asrc", 32'(asrc), 32'(as));
    chk("R3 fs_code", 32'(fs_code), 32'(fs));
    chk("R4 oe stays", 32'(pin_oe), 32'hFF);
    chk_mode(fs_code);
    psave_n = 1'b0;
    tick();
    chk("R8 psave code", 32'(fs_code), 32'({3'b100, fs[1:0]}));
    chk("R8 rb untouched", 32'(fs_rb), 32'(fs));
    chk_mode(fs_code);
    psave_n = 1'b1;
    tick();
    chk("R8 restore", 32'(fs_code), 32'(fs));
    en = p[6:5] ^ p[1:0];
    dat = ~fs[4:3];
    wr_en = en; wr_data = dat;
    tick();
    wr_en = '0; wr_data = '0;
    exp = fs;
    if (en[1]) exp[4] = dat[1];
    if (en[0]) exp[3] = dat[0];
    chk("R7 fs_rb", 32'(fs_rb), 32'(exp));
    chk("R7 fs_code", 32'(fs_code), 32'(exp));
    chk_mode(fs_code);
    psave_n = 1'b0;
    tick();
    chk("R8 psave after write", 32'(fs_code), 32'({3'b100, exp[1:0]}));
    psave_n = 1'b1;
    tick();
    chk("R7 R8 held", 32'(fs_code), 32'(exp));
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwrgd_n = 1'b1; psave_n = 1'b1; asel = 1'b0;
    fs_pin = '0; epci_pin = '0; wr_en = '0; wr_data = '0;
    for (int p = 0; p < 256; p++) run_one(p);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule